// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Static Memory Model

This block is a synthesizable stand-in for an asynchronous 16-bit static memory made of two equal banks. Both banks share one word address. Each bank has its own active-low select. Writes and reads are gated per byte lane by separate active-low lower and upper byte enables. It serves as a testbench target or as an on-chip replacement where a real memory part is absent.

The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive enable. A lane whose drive enable is low stands for a high-impedance lane, and its read-data bits are held at zero.

Writes are committed at the rising clock edge of a cycle in which the write condition holds. Reads present the addressed word combinationally from the registered storage. The bank depth is a parameter, and the incoming address is reduced modulo that depth.

Top module: `dual_bank_sram`

## Requirements
- R1: After reset every word of both banks reads as 0x0000.
- R2: With only `sel0_n` low and `wr_n` low, the enabled lanes of `wdata` are stored in bank 0 at the addressed word on the next rising clock edge. The level of `rd_n` has no effect on a write.
- R3: With only `sel1_n` low, accesses go to bank 1. The same address in bank 0 and bank 1 holds independent words.
- R4: Lane 0 is bits 7:0 and is gated by `lo_n`. Lane 1 is bits 15:8 and is gated by `hi_n`. During a write, a lane whose enable is high keeps its previous content.
- R5: A read occurs when exactly one select is low, `wr_n` is high and `rd_n` is low. `drive[0]` equals `!lo_n` and `drive[1]` equals `!hi_n`. Each driven lane carries the stored byte, and each undriven lane reads 0.
- R6: With both selects high, `drive` is 00 and `rdata` is 0x0000, and writes change no stored word.
- R7: With one bank selected and `wr_n` high, either `rd_n` high or both byte enables high gives `drive` = 00 and `rdata` = 0x0000.
- R8: While a write is in progress (`wr_n` low), `drive` is 00.
- R9: With both selects low, `clash` is 1, neither bank is written and `drive` is 00. Otherwise `clash` is 0.
- R10: The word index is the address modulo DEPTH, so addresses that differ by a multiple of DEPTH reach the same word.
- R11: A word written at a clock edge is visible on `rdata` in the very next cycle, with no added read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that commits writes |
| rst_n | input | 1 | Active-low reset, clears storage |
| addr | input | 18 | Word address shared by both banks |
| sel0_n | input | 1 | Active-low select of bank 0 |
| sel1_n | input | 1 | Active-low select of bank 1 |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low output enable |
| lo_n | input | 1 | Active-low enable of lane 0 (bits 7:0) |
| hi_n | input | 1 | Active-low enable of lane 1 (bits 15:8) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| drive | output | 2 | Per-lane drive enable, bit 0 = lane 0 |
| clash | output | 1 | Both selects low at once |

## Verification
The directed patterns cover the following cases:
- A full-word write and read-back in each bank at the same address, which separates the two banks from one shared array.
- Single-lane writes over a known word, which show whether the masked lane is really held.
- Reads with one lane enabled, which tell a correct lane split from swapped lanes.
- Writes with `rd_n` both low and high, which show that output enable has no effect on writes.
- A write followed by a read at an aliased address, which exposes a wrong address reduction.
- A write with both selects low followed by read-back, which tells a suppressed clash write from a leaked one.

Seeded random cycles then mix every select, enable and lane combination against a reference array kept in the bench.

// File: rtl/dbsram_pkg.sv
package dbsram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_CLASH = 2'd3
  } acc_e;

  // Classify the control pins into one access kind.
  function automatic acc_e classify(input logic s0_n, input logic s1_n,
                                    input logic w_n, input logic r_n);
    if (!s0_n && !s1_n)     return ACC_CLASH;
    else if (s0_n && s1_n)  return ACC_IDLE;
    else if (!w_n)          return ACC_WRITE;
    else if (!r_n)          return ACC_READ;
    else                    return ACC_IDLE;
  endfunction

  // Active-high lane mask: bit 0 lower byte, bit 1 upper byte.
  function automatic logic [1:0] lanes_of(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

  // Expand a lane mask to a bit mask over the 16-bit word.
  function automatic logic [15:0] bit_mask(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

endpackage

// File: rtl/dbsram_decode.sv
module dbsram_decode
  import dbsram_pkg::*;
(
  input  logic       sel0_n,
  input  logic       sel1_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       lo_n,
  input  logic       hi_n,
  output acc_e       acc,
  output logic       bank_pick,
  output logic [1:0] wr_lanes,
  output logic [1:0] rd_lanes
);
  logic [1:0] lanes;

  always_comb begin
    acc       = classify(sel0_n, sel1_n, wr_n, rd_n);
    lanes     = lanes_of(lo_n, hi_n);
    bank_pick = sel0_n;  // bank 1 only when sel0_n is high
    wr_lanes  = (acc == ACC_WRITE) ? lanes : 2'b00;
    rd_lanes  = (acc == ACC_READ)  ? lanes : 2'b00;
  end
endmodule

// File: rtl/dbsram_bank.sv
module dbsram_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANES = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) mem[w][ln*8 +: 8] <= '0;
      end else if (wr_lanes[ln]) begin
        mem[idx][ln*8 +: 8] <= wdata[ln*8 +: 8];
      end
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram
  import dbsram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 18,
  localparam int WIDTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              lo_n,
  input  logic              hi_n,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic [1:0]        drive,
  output logic              clash
);
  acc_e             acc;
  logic             bank_pick;
  logic [1:0]       wr_lanes, rd_lanes;
  logic [IDX_W-1:0] idx;
  logic [1:0]       bank_wr [2];
  logic [WIDTH-1:0] bank_rd [2];
  logic [WIDTH-1:0] word_sel;

  assign idx = IDX_W'(addr % ADDR_W'(DEPTH));

  dbsram_decode u_dec (
    .sel0_n   (sel0_n),
    .sel1_n   (sel1_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .lo_n     (lo_n),
    .hi_n     (hi_n),
    .acc      (acc),
    .bank_pick(bank_pick),
    .wr_lanes (wr_lanes),
    .rd_lanes (rd_lanes)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_wr[b] = (bank_pick == b[0]) ? wr_lanes : 2'b00;
    dbsram_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .wr_lanes(bank_wr[b]),
      .wdata   (wdata),
      .rdata   (bank_rd[b])
    );
  end

  assign word_sel = bank_pick ? bank_rd[1] : bank_rd[0];
  assign rdata    = word_sel & bit_mask(rd_lanes);
  assign drive    = rd_lanes;
  assign clash    = (acc == ACC_CLASH);

  // R2: a bank write strobe needs write enable and exactly one select
  p_write_needs_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_wr[0]) || (|bank_wr[1])) |-> (!wr_n && (sel0_n ^ sel1_n)));

  // R9: a select clash never reaches a bank
  p_clash_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (bank_wr[0] == 2'b00 && bank_wr[1] == 2'b00 && drive == 2'b00));

  // R5: lanes drive only in a read
  p_drive_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|drive) |-> (wr_n && !rd_n && (sel0_n ^ sel1_n)));

  // R6: deselected part is quiet
  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0_n && sel1_n) |-> (drive == 2'b00 && rdata == '0));

  // R8: no drive during a write
  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (drive == 2'b00));
endmodule

// File: tb/dual_bank_sram_test.sv
`timescale 1ns/1ps
module dual_bank_sram_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic sel0_n = 1'b1, sel1_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  drive;
  logic        clash;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [2][DEPTH];

  always #5 clk = ~clk;

  dual_bank_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .wr_n(wr_n), .rd_n(rd_n), .lo_n(lo_n), .hi_n(hi_n), .wdata(wdata),
    .rdata(rdata), .drive(drive), .clash(clash)
  );

  function automatic logic one_sel();
    return sel0_n ^ sel1_n;
  endfunction

  function automatic logic [1:0] exp_drive();
    if (one_sel() && wr_n && !rd_n) return {!hi_n, !lo_n};
    return 2'b00;
  endfunction

  function automatic logic [15:0] exp_data();
    logic [1:0]  d = exp_drive();
    logic [15:0] w = model[sel0_n ? 1 : 0][addr % DEPTH];
    return {d[1] ? w[15:8] : 8'h00, d[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic check(input string tag);
    logic [15:0] ed = exp_data();
    logic [1:0]  eo = exp_drive();
    logic        ec = !sel0_n && !sel1_n;
    checks++;
    if (rdata !== ed || drive !== eo || clash !== ec) begin
      fails++;
      $display("FAIL %s: rdata=%h drive=%b clash=%b expected %h %b %b",
               tag, rdata, drive, clash, ed, eo, ec);
    end
  endtask

  // Drive one cycle at the falling edge, check before the rising edge,
  // then update the reference for any write committed at that edge.
  task automatic cyc(input logic [17:0] a, input logic s0, input logic s1,
                     input logic w, input logic r, input logic l, input logic h,
                     input logic [15:0] d, input string tag);
    @(negedge clk);
    addr = a; sel0_n = s0; sel1_n = s1; wr_n = w; rd_n = r; lo_n = l; hi_n = h; wdata = d;
    #2;
    check(tag);
    if (one_sel() && !wr_n) begin
      if (!lo_n) model[sel0_n ? 1 : 0][addr % DEPTH][7:0]  = wdata[7:0];
      if (!hi_n) model[sel0_n ? 1 : 0][addr % DEPTH][15:8] = wdata[15:8];
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < DEPTH; i++) model[b][i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check("R6 reset idle");
    @(negedge clk) rst_n = 1'b1;

    // R1: all zero after reset
    for (int i = 0; i < DEPTH; i++) cyc(18'(i), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R1 bank0");
    for (int i = 0; i < DEPTH; i++) cyc(18'(i), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R1 bank1");

    // R2/R3: same address, independent banks; rd_n level irrelevant on write
    cyc(18'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA1B2, "R8 write b0");
    cyc(18'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC3D4, "R8 write b1");
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R2 read b0");
    cyc(18'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R3 read b1");

    // R4: lane masking on write, R11: immediate visibility
    cyc(18'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFEE, "R4 lo write");
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R11 read after lo");
    cyc(18'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7766, "R4 hi write");
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 read back");

    // R5: single lane reads
    cyc(18'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R5 lo only");
    cyc(18'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R5 hi only");

    // R7: output disabled
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7 rd_n high");
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0, "R7 no lanes");

    // R6: write while deselected has no effect
    cyc(18'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, "R6 deselect write");
    cyc(18'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6 read back");

    // R9: clash suppresses writes to both banks
    cyc(18'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h5A5A, "R9 clash write");
    cyc(18'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R9 bank0 clean");
    cyc(18'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R9 bank1 clean");

    // R10: aliasing modulo DEPTH
    cyc(18'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0BAD, "R10 write");
    cyc(18'(3 + DEPTH * 7), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R10 alias read");

    // Seeded random traffic
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom % 8);
      logic s0 = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : k[0];
      logic s1 = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : ~k[0];
      logic w  = $urandom % 2 == 0;
      logic r  = $urandom % 2 == 0;
      logic l  = $urandom % 3 == 0;
      logic h  = $urandom % 3 == 0;
      string tag = (!s0 && !s1) ? "R9 rand" : (s0 && s1) ? "R6 rand" :
                   !w ? "R8 rand" : !r ? "R5 rand" : "R7 rand";
      cyc(18'($urandom), s0, s1, w, r, l, h, 16'($urandom), tag);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule